// File: doc/BRIEF.md
# Quasi-Bidirectional I/O Port with Comparator Input Bit

This block is the register side of an 8-bit general-purpose I/O port in a small 8051-style microcontroller. Each pin has an output latch. A latch holding 0 pulls its pad low. A latch holding 1 releases the pad to its weak pull-up, so an external device can pull the pad low and the pin then works as an input. Software writes the whole latch at once, or changes a single bit. A single-bit change works from the latch contents and not from the pad levels, so a pin that some other device holds low is not cleared by accident.

One bit position, bit 6 by default, has no pad. It returns the digital output of an on-chip comparator. Writes to that bit can never pull a pad low. There are two read paths. The latch read returns the stored latch value directly. The pin read returns the pad levels, and the comparator result in the comparator bit, each passed through a two-flop synchronizer. An asynchronous reset puts every latch at 1 at once, which releases all pads.

Top module: `qbp_port`

## Requirements
- R1: While `rst` is high, `latch_rd` is all ones and `pad_pull_low` is all zeros, without waiting for a clock edge. The synchronizer flops also reset to ones, so `pin_rd` reads all ones during reset.
- R2: When `wr_en` is high at a rising clock edge, the latch takes `wr_data`. `latch_rd` shows the new value after that edge.
- R3: For every bit other than the comparator bit, a latch value of 0 gives `pad_pull_low` = 1 (pad driven low). A latch value of 1 gives `pad_pull_low` = 0 (pad released to its pull-up).
- R4: `pad_pull_low[6]` (the comparator bit, `CMP_BIT` = 6) is always 0, whatever is written. The latch still stores bit 6, and `latch_rd[6]` shows the value written there.
- R5: For every bit other than bit 6, `pin_rd[i]` follows `pad_in[i]` through two flops. A change that is present before rising edge k shows on `pin_rd` after edge k+1, and is not yet visible after edge k.
- R6: `pin_rd[6]` follows `cmp_in` with the same two-edge latency. It does not depend on `pad_in[6]` or on `latch_rd[6]`.
- R7: When `bit_wr_en` is high and `wr_en` is low at a rising edge, only latch bit `bit_sel` (a binary bit index) takes `bit_val`. Every other latch bit keeps its latch value, even when its pad is held low from outside.
- R8: When `wr_en` and `bit_wr_en` are both high at the same edge, the whole-port write takes effect and the bit write is dropped.
- R9: When neither `wr_en` nor `bit_wr_en` is high at an edge, the latch keeps its value, whatever `wr_data` carries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Port clock |
| rst | input | 1 | Asynchronous reset, active high |
| wr_en | input | 1 | Whole-port latch write strobe |
| wr_data | input | 8 | Value for a whole-port write |
| bit_wr_en | input | 1 | Single-bit latch write strobe |
| bit_sel | input | 3 | Binary index of the bit that a single-bit write changes |
| bit_val | input | 1 | New value of the selected bit |
| pad_in | input | 8 | Sensed pad levels (bit 6 unused) |
| cmp_in | input | 1 | Digital comparator result |
| latch_rd | output | 8 | Latch read path |
| pin_rd | output | 8 | Synchronized pin read path, comparator in bit 6 |
| pad_pull_low | output | 8 | 1 = drive the pad low, 0 = release it to the pull-up |

## Verification
The embedded assertions check on every cycle how each kind of write (whole-port, single-bit, none) moves the latch, that the comparator bit never pulls a pad low, that a cleared general bit pulls its pad low after a write, and the two-edge delay from `pad_in` and `cmp_in` to `pin_rd`. Some behaviour only the bench scenarios can show, because they model the pad as a wired-AND of the latch drive and an external driver with a pull-up. These are the quasi-bidirectional read-back of externally pulled pins, the fact that a single-bit write is not disturbed by a pad held low from outside, and the latch forcing itself to ones partway through a clock cycle when reset rises.

// File: rtl/qbp_pkg.sv
package qbp_pkg;

  // Kind of latch update chosen in a given cycle; byte write wins over bit write.
  typedef enum logic [1:0] {
    WR_NONE = 2'd0,
    WR_BYTE = 2'd1,
    WR_BIT  = 2'd2
  } wr_kind_e;

  function automatic wr_kind_e pick_write(input logic byte_req, input logic bit_req);
    if (byte_req) return WR_BYTE;
    if (bit_req)  return WR_BIT;
    return WR_NONE;
  endfunction

endpackage

// File: rtl/qbp_latch.sv
module qbp_latch
  import qbp_pkg::*;
#(
  parameter int WIDTH = 8,
  localparam int SELW = (WIDTH > 1) ? $clog2(WIDTH) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [WIDTH-1:0] wr_data,
  input  logic             bit_wr_en,
  input  logic [SELW-1:0]  bit_sel,
  input  logic             bit_val,
  output logic [WIDTH-1:0] latch_q
);

  // One-hot mask of the bit addressed by a single-bit write.
  function automatic logic [WIDTH-1:0] sel_mask(input logic [SELW-1:0] sel);
    logic [WIDTH-1:0] m;
    m = '0;
    for (int i = 0; i < WIDTH; i++) begin
      if (SELW'(i) == sel) m[i] = 1'b1;
    end
    return m;
  endfunction

  // New latch contents for a single-bit write: based on the latch, never the pad.
  function automatic logic [WIDTH-1:0] merge_bit(input logic [WIDTH-1:0] cur,
                                                 input logic [SELW-1:0]  sel,
                                                 input logic             val);
    logic [WIDTH-1:0] m;
    m = sel_mask(sel);
    return (cur & ~m) | (val ? m : '0);
  endfunction

  wr_kind_e         wr_kind;
  logic [WIDTH-1:0] latch_next;

  assign wr_kind = pick_write(wr_en, bit_wr_en);

  always_comb begin
    unique case (wr_kind)
      WR_BYTE: latch_next = wr_data;
      WR_BIT:  latch_next = merge_bit(latch_q, bit_sel, bit_val);
      default: latch_next = latch_q;
    endcase
  end

  always_ff @(posedge clk or posedge rst) begin
    if (rst) latch_q <= '1;
    else     latch_q <= latch_next;
  end

  // R1
  reset_ones_chk: assert property (@(posedge clk) rst |-> (latch_q == '1))
    else $error("latch not all ones during reset");

  // R2 R8
  byte_write_chk: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> (latch_q == $past(wr_data)))
    else $error("byte write did not load latch");

  // R7
  bit_target_chk: assert property (@(posedge clk) disable iff (rst)
    (bit_wr_en && !wr_en) |=> ((latch_q & sel_mask($past(bit_sel))) ==
                               ($past(bit_val) ? sel_mask($past(bit_sel)) : '0)))
    else $error("bit write did not set selected bit");

  // R7
  bit_others_chk: assert property (@(posedge clk) disable iff (rst)
    (bit_wr_en && !wr_en) |=> (((latch_q ^ $past(latch_q)) & ~sel_mask($past(bit_sel))) == '0))
    else $error("bit write disturbed other bits");

  // R9
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!wr_en && !bit_wr_en) |=> $stable(latch_q))
    else $error("latch changed without write");

endmodule

// File: rtl/qbp_drive.sv
module qbp_drive #(
  parameter int WIDTH   = 8,
  parameter int CMP_BIT = 6
) (
  input  logic [WIDTH-1:0] latch_q,
  output logic [WIDTH-1:0] pull_low
);

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    if (i == CMP_BIT) begin : g_cmp
      assign pull_low[i] = 1'b0;
    end else begin : g_io
      assign pull_low[i] = ~latch_q[i];
    end
  end

endmodule

// File: rtl/qbp_pinsel.sv
module qbp_pinsel #(
  parameter int WIDTH   = 8,
  parameter int CMP_BIT = 6
) (
  input  logic [WIDTH-1:0] pad_in,
  input  logic             cmp_in,
  output logic [WIDTH-1:0] sense
);

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    if (i == CMP_BIT) begin : g_cmp
      assign sense[i] = cmp_in;
    end else begin : g_io
      assign sense[i] = pad_in[i];
    end
  end

endmodule

// File: rtl/qbp_sync.sv
module qbp_sync #(
  parameter int WIDTH  = 8,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  logic [WIDTH-1:0] stage [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or posedge rst) begin
        if (rst) stage[s] <= '1;
        else     stage[s] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk or posedge rst) begin
        if (rst) stage[s] <= '1;
        else     stage[s] <= stage[s-1];
      end
    end
  end

  assign q = stage[STAGES-1];

  // Edges seen since reset, saturating; gates the latency check.
  logic [1:0] age;
  always_ff @(posedge clk or posedge rst) begin
    if (rst)            age <= 2'd0;
    else if (age != 2'd2) age <= age + 2'd1;
  end

  if (STAGES == 2) begin : g_lat_chk
    // R5 R6
    sync_latency_chk: assert property (@(posedge clk) disable iff (rst)
      (age == 2'd2) |-> (q == $past(d, 2)))
      else $error("synchronizer latency wrong");
  end

endmodule

// File: rtl/qbp_port.sv
module qbp_port #(
  parameter int WIDTH   = 8,
  parameter int CMP_BIT = 6,
  parameter int STAGES  = 2,
  localparam int SELW   = (WIDTH > 1) ? $clog2(WIDTH) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [WIDTH-1:0] wr_data,
  input  logic             bit_wr_en,
  input  logic [SELW-1:0]  bit_sel,
  input  logic             bit_val,
  input  logic [WIDTH-1:0] pad_in,
  input  logic             cmp_in,
  output logic [WIDTH-1:0] latch_rd,
  output logic [WIDTH-1:0] pin_rd,
  output logic [WIDTH-1:0] pad_pull_low
);

  logic [WIDTH-1:0] latch_q;
  logic [WIDTH-1:0] sense;

  qbp_latch #(.WIDTH(WIDTH)) u_latch (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
    .bit_wr_en(bit_wr_en), .bit_sel(bit_sel), .bit_val(bit_val),
    .latch_q(latch_q)
  );

  qbp_drive #(.WIDTH(WIDTH), .CMP_BIT(CMP_BIT)) u_drive (
    .latch_q(latch_q), .pull_low(pad_pull_low)
  );

  qbp_pinsel #(.WIDTH(WIDTH), .CMP_BIT(CMP_BIT)) u_pinsel (
    .pad_in(pad_in), .cmp_in(cmp_in), .sense(sense)
  );

  qbp_sync #(.WIDTH(WIDTH), .STAGES(STAGES)) u_sync (
    .clk(clk), .rst(rst), .d(sense), .q(pin_rd)
  );

  assign latch_rd = latch_q;

  // R1
  reset_release_chk: assert property (@(posedge clk) rst |-> (pad_pull_low == '0))
    else $error("pad driven low during reset");

  // R4
  cmp_no_drive_chk: assert property (@(posedge clk) disable iff (rst)
    !pad_pull_low[CMP_BIT])
    else $error("comparator bit drives a pad");

  for (genvar i = 0; i < WIDTH; i++) begin : g_drv_chk
    if (i != CMP_BIT) begin : g_io
      // R3
      drive_after_write_chk: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> (pad_pull_low[i] == !$past(wr_data[i])))
        else $error("pad drive does not follow written latch");
    end
  end

endmodule

// File: tb/qbp_port_test.sv
module qbp_port_test;

  logic       clk = 1'b0;
  logic       rst;
  logic       wr_en, bit_wr_en, bit_val, cmp_in;
  logic [7:0] wr_data, pad_in, latch_rd, pin_rd, pad_pull_low, ext_drv;
  logic [2:0] bit_sel;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  // Pad model: wired-AND of the port's pull-down and an external driver over a pull-up.
  assign pad_in = ~pad_pull_low & ext_drv;

  qbp_port uut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
    .bit_wr_en(bit_wr_en), .bit_sel(bit_sel), .bit_val(bit_val),
    .pad_in(pad_in), .cmp_in(cmp_in),
    .latch_rd(latch_rd), .pin_rd(pin_rd), .pad_pull_low(pad_pull_low)
  );

  task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  // {wr_data, ext_drv, cmp, expected pad_pull_low, expected pin_rd}
  localparam logic [39:0] VEC [7] = '{
    {8'hFF, 8'hFF, 8'h00, 8'h00, 8'hBF},
    {8'h00, 8'hFF, 8'h01, 8'hBF, 8'h40},
    {8'hF0, 8'h3C, 8'h00, 8'h0F, 8'h30},
    {8'h55, 8'hFF, 8'h01, 8'hAA, 8'h55},
    {8'hAA, 8'h0F, 8'h00, 8'h15, 8'h0A},
    {8'hBF, 8'h7E, 8'h01, 8'h00, 8'h7E},
    {8'h40, 8'hFF, 8'h00, 8'hBF, 8'h00}
  };

  initial begin
    #(200000 * 5);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; wr_en = 1'b0; bit_wr_en = 1'b0; bit_val = 1'b0;
    bit_sel = 3'd0; wr_data = 8'h00; cmp_in = 1'b0; ext_drv = 8'hFF;
    tick(3);
    // R1 reset state
    chk("R1 latch", latch_rd, 8'hFF);
    chk("R1 drive", pad_pull_low, 8'h00);
    chk("R1 pin", pin_rd, 8'hFF);
    rst = 1'b0;
    tick(1);

    // Table walk: R2 R3 R4 R5 R6
    for (int v = 0; v < 7; v++) begin
      wr_en = 1'b1; wr_data = VEC[v][39:32]; ext_drv = VEC[v][31:24];
      cmp_in = VEC[v][16];
      tick(1);
      wr_en = 1'b0;
      chk("R2 latch", latch_rd, VEC[v][39:32]);
      chk("R3 R4 drive", pad_pull_low, VEC[v][15:8]);
      tick(2);
      chk("R5 R6 pin", pin_rd, VEC[v][7:0]);
    end

    // R9: data bus noise without strobe
    wr_data = 8'h3C; tick(1); wr_data = 8'hC3; tick(1);
    chk("R9 hold", latch_rd, 8'h40);

    // R5 latency: release all, then pull bit 0 low externally
    wr_en = 1'b1; wr_data = 8'hFF; ext_drv = 8'hFF; cmp_in = 1'b0; tick(1);
    wr_en = 1'b0; tick(3);
    ext_drv = 8'hFE;
    tick(1);
    chk("R5 one edge", pin_rd, 8'hBF);
    tick(1);
    chk("R5 two edges", pin_rd, 8'hBE);

    // R6: comparator independent of pad bit 6 and latch bit 6
    ext_drv = 8'hBF; cmp_in = 1'b1; tick(2);
    chk("R6 cmp high", pin_rd & 8'h40, 8'h40);
    ext_drv = 8'hFF; cmp_in = 1'b0; tick(2);
    chk("R6 cmp low", pin_rd & 8'h40, 8'h00);

    // R7: bit write uses latch, not pad (bit 3 held low outside)
    ext_drv = 8'hF7; tick(2);
    chk("R7 pad seen low", pin_rd, 8'hB7);
    bit_wr_en = 1'b1; bit_sel = 3'd5; bit_val = 1'b0; tick(1);
    bit_wr_en = 1'b0;
    chk("R7 latch", latch_rd, 8'hDF);
    chk("R7 drive", pad_pull_low, 8'h20);
    bit_wr_en = 1'b1; bit_sel = 3'd5; bit_val = 1'b1; tick(1);
    bit_wr_en = 1'b0;
    chk("R7 set back", latch_rd, 8'hFF);

    // R4: bit write to comparator bit stores but never drives
    bit_wr_en = 1'b1; bit_sel = 3'd6; bit_val = 1'b0; tick(1);
    bit_wr_en = 1'b0;
    chk("R4 latch", latch_rd, 8'hBF);
    chk("R4 drive", pad_pull_low, 8'h00);

    // R8: byte write wins
    wr_en = 1'b1; wr_data = 8'h12; bit_wr_en = 1'b1; bit_sel = 3'd1; bit_val = 1'b0;
    tick(1);
    wr_en = 1'b0; bit_wr_en = 1'b0;
    chk("R8 priority", latch_rd, 8'h12);

    // R1: asynchronous reset mid-cycle
    wr_en = 1'b1; wr_data = 8'h00; tick(1); wr_en = 1'b0;
    chk("R1 pre", latch_rd, 8'h00);
    #1 rst = 1'b1;
    #0.5;
    chk("R1 async latch", latch_rd, 8'hFF);
    chk("R1 async drive", pad_pull_low, 8'h00);
    tick(1);
    rst = 1'b0;
    tick(1);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule